// File: doc/BRIEF.md
# Timestamp Snapshot Lock Channel

This block is one channel of a network time-synchronization assist. When the MAC reports a start-of-frame delimiter, the block copies a free-running 64-bit system time value into a snapshot register. A message classifier decides a few cycles later whether that frame was a synchronization message, a delay-request message or something else. If the decision qualifies for the channel's role, the snapshot freezes. It then stays frozen until software writes a release, so the time of the relevant message cannot be lost while software is slow to respond.

A control register selects the role. Slave channels freeze on sync messages and master channels freeze on delay requests. A capture-all bit turns freezing off completely, so that every delimiter overwrites the snapshot. Software reads the 64-bit snapshot as two 32-bit words, low word first. Reading the low word also holds the matching high word, so the pair stays consistent.

Top module: `tsl_channel`

## Requirements
- R1: After reset the control register reads 0 (slave role, freezing enabled), the lock status reads 0 and `locked_o` is 0.
- R2: The control register sits at byte address 0x040 + 0x20 × CHAN. Bit 0 is the master-role bit and bit 1 is the capture-all bit. Bits 31:2 read 0. Writes to any other channel's address leave it unchanged.
- R3: A `sfd` pulse while unlocked copies `sys_time` into the snapshot, which is visible on the next cycle.
- R4: In the slave role, a classifier decision (`msg_valid`) of type 0 (sync) on a pending snapshot locks it. Type 1 (delay request) and type 2 (other) do not.
- R5: In the master role, a decision of type 1 (delay request) locks the snapshot. Type 0 and type 2 do not.
- R6: While locked, further `sfd` pulses leave the snapshot unchanged.
- R7: With capture-all set, no decision ever locks, and every `sfd` overwrites the snapshot.
- R8: The status word at control address + 0x04 shows the lock in bit 0. Writing 1 to bit 0 releases the lock, and writing 0 has no effect.
- R9: If a release write and a locking decision arrive in the same cycle, the channel ends up locked.
- R10: Reading the low word (control address + 0x08) returns snapshot bits 31:0 and holds bits 63:32. Reading control address + 0x0C returns the held high word.
- R11: A decision that arrives with no delimiter since the previous decision does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time |
| sfd | input | 1 | Start-of-frame delimiter pulse |
| msg_valid | input | 1 | Classifier decision strobe |
| msg_type | input | 2 | 0 sync, 1 delay request, 2 other |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| locked_o | output | 1 | Snapshot is locked |

## Verification
The bench sweeps both roles, both capture-all settings and all three message types. For each combination it follows the first frame with a second, non-qualifying frame. A wrong role decode would freeze on the wrong message type. A leaky lock would let the second frame's time replace the first. A design that ignored capture-all would freeze when it should keep overwriting. Separate cases cover these faults:
- a release and a lock colliding in the same cycle, where a wrong priority leaves the channel unlocked;
- a decision without a delimiter, which would freeze a stale time;
- a split read across an overwrite, which would tear the two halves.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    MSG_SYNC  = 2'd0,
    MSG_DREQ  = 2'd1,
    MSG_OTHER = 2'd2
  } msg_kind_t;

  localparam logic [31:0] OFF_CTRL   = 32'h0;
  localparam logic [31:0] OFF_STAT   = 32'h4;
  localparam logic [31:0] OFF_SNAPLO = 32'h8;
  localparam logic [31:0] OFF_SNAPHI = 32'hC;

  // byte address of a channel's control word
  function automatic logic [31:0] chan_base(input int unsigned idx);
    return 32'h40 + 32'h20 * idx;
  endfunction

  // does a decision of this kind freeze the snapshot for this role
  function automatic logic qualifies(input logic master, input logic [1:0] kind);
    return master ? (kind == MSG_DREQ) : (kind == MSG_SYNC);
  endfunction
endpackage

// File: rtl/tsl_lock.sv
module tsl_lock
  import tsl_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          sfd,
  input  logic          msg_valid,
  input  logic [1:0]    msg_type,
  input  logic          master,
  input  logic          ts_all,
  input  logic          rel_req,
  output logic [TW-1:0] snapshot,
  output logic          locked,
  output logic          lock_set,
  output logic          capture
);
  logic pending;

  assign lock_set = msg_valid & pending & ~ts_all & ~locked & qualifies(master, msg_type);
  assign capture  = sfd & ~locked & ~lock_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapshot <= '0;
      pending  <= 1'b0;
      locked   <= 1'b0;
    end else begin
      if (capture) snapshot <= sys_time;
      if (capture)        pending <= 1'b1;
      else if (msg_valid) pending <= 1'b0;
      if (lock_set)     locked <= 1'b1;
      else if (rel_req) locked <= 1'b0;
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> snapshot == $past(sys_time));
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(snapshot));
  a_r9_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);
  a_r7_no_lock_all: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_all && !locked) |=> !locked);
endmodule

// File: rtl/tsl_regs.sv
module tsl_regs
  import tsl_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int CHAN = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            locked,
  input  logic [2*DW-1:0] snapshot,
  output logic [DW-1:0]   bus_rdata,
  output logic            master,
  output logic            ts_all,
  output logic            rel_req
);
  localparam logic [31:0] BASE = chan_base(CHAN);

  logic [31:0]   addr_ext;
  logic          sel_ctrl, sel_stat, sel_lo, sel_hi;
  logic [DW-1:0] hi_hold;

  assign addr_ext = 32'(bus_addr);
  assign sel_ctrl = addr_ext == BASE + OFF_CTRL;
  assign sel_stat = addr_ext == BASE + OFF_STAT;
  assign sel_lo   = addr_ext == BASE + OFF_SNAPLO;
  assign sel_hi   = addr_ext == BASE + OFF_SNAPHI;
  assign rel_req  = bus_wr & sel_stat & bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master  <= 1'b0;
      ts_all  <= 1'b0;
      hi_hold <= '0;
    end else begin
      if (bus_wr && sel_ctrl) begin
        master <= bus_wdata[0];
        ts_all <= bus_wdata[1];
      end
      if (bus_rd && sel_lo) hi_hold <= snapshot[2*DW-1:DW];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)    bus_rdata = {{(DW-2){1'b0}}, ts_all, master};
    else if (sel_stat) bus_rdata = {{(DW-1){1'b0}}, locked};
    else if (sel_lo) bus_rdata = snapshot[DW-1:0];
    else if (sel_hi) bus_rdata = hi_hold;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_lo) |=> hi_hold == $past(snapshot[2*DW-1:DW]));
endmodule

// File: rtl/tsl_channel.sv
module tsl_channel
  import tsl_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int CHAN = 1,
  localparam int TW  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          sfd,
  input  logic          msg_valid,
  input  logic [1:0]    msg_type,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          locked_o
);
  logic          master, ts_all, rel_req;
  logic          locked, lock_set, capture;
  logic [TW-1:0] snapshot;

  tsl_regs #(.AW(AW), .DW(DW), .CHAN(CHAN)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .locked, .snapshot, .bus_rdata, .master, .ts_all, .rel_req
  );

  tsl_lock #(.TW(TW)) u_lock (
    .clk, .rst_n, .sys_time, .sfd, .msg_valid, .msg_type,
    .master, .ts_all, .rel_req, .snapshot, .locked, .lock_set, .capture
  );

  assign locked_o = locked;

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !lock_set) |=> !locked_o);
  a_r6_no_capture_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !capture);
endmodule

// File: tb/tb_tsl_channel.sv
`timescale 1ns/100ps
module tb_tsl_channel;
  localparam int CHAN = 1;
  localparam logic [11:0] BASE = 12'h040 + 12'h020 * CHAN;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] sys_time = '0;
  logic        sfd = 0, msg_valid = 0;
  logic [1:0]  msg_type = 0;
  logic [11:0] bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        locked_o;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  tsl_channel #(.CHAN(CHAN)) dut (.*);

  function automatic logic [63:0] pat(input int k);
    return {32'(k) * 32'h9E37_79B9, ~32'(k) ^ 32'h5A5A_0F0F};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic frame(input logic [63:0] t, input logic [1:0] kind);
    @(negedge clk); sys_time = t; sfd = 1;
    @(negedge clk); sfd = 0; msg_valid = 1; msg_type = kind;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic read_snap(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(BASE + 12'h8, lo);
    rd(BASE + 12'hC, hi);
    s = {hi, lo};
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(BASE, d);          chk("R1 ctrl", d, 0);
    rd(BASE + 12'h4, d);  chk("R1 status", d, 0);
    chk("R1 locked_o", locked_o, 0);

    // R2 field layout and channel decode
    wr(BASE, 32'hFFFF_FFFF); rd(BASE, d); chk("R2 ctrl bits", d, 32'h3);
    wr(BASE, 0);
    wr(12'h040, 32'h3); rd(BASE, d); chk("R2 other chan", d, 0);
    wr(12'h080, 32'h3); rd(BASE, d); chk("R2 other chan", d, 0);

    // R3 R4 R5 R6 R7 R8 sweep
    for (int m = 0; m < 2; m++)
      for (int ta = 0; ta < 2; ta++)
        for (int k = 0; k < 3; k++) begin
          logic exp_lock;
          logic [63:0] a, b;
          int idx;
          idx = m * 6 + ta * 3 + k + 1;
          a = pat(idx); b = pat(idx + 100);
          exp_lock = !ta && (m ? (k == 1) : (k == 0));
          wr(BASE, {30'd0, 1'(ta), 1'(m)});
          frame(a, 2'(k));
          read_snap(s); chk("R3 capture", s, a);
          rd(BASE + 12'h4, d);
          chk(m ? "R5 lock by role" : "R4 lock by role", d, {31'd0, exp_lock});
          if (ta) chk("R7 no lock when capture-all", d, 0);
          frame(b, 2'd2);
          read_snap(s);
          chk(exp_lock ? "R6 locked hold" : "R7 overwrite", s, exp_lock ? a : b);
          wr(BASE + 12'h4, 0);
          rd(BASE + 12'h4, d); chk("R8 write 0 no effect", d, {31'd0, exp_lock});
          wr(BASE + 12'h4, 1);
          rd(BASE + 12'h4, d); chk("R8 release", d, 0);
          chk("R8 locked_o", locked_o, 0);
        end

    // R10 split read across overwrite
    wr(BASE, 32'h2);
    frame(pat(200), 2'd0);
    rd(BASE + 12'h8, d); chk("R10 low", d, pat(200)[31:0]);
    frame(pat(201), 2'd0);
    rd(BASE + 12'hC, d); chk("R10 held high", d, pat(200)[63:32]);
    read_snap(s); chk("R10 new pair", s, pat(201));

    // R9 release and lock in same cycle
    wr(BASE, 0);
    @(negedge clk); sys_time = pat(300); sfd = 1;
    @(negedge clk); sfd = 0; msg_valid = 1; msg_type = 2'd0;
    bus_addr = BASE + 12'h4; bus_wdata = 1; bus_wr = 1;
    @(negedge clk); msg_valid = 0; bus_wr = 0;
    chk("R9 lock wins", locked_o, 1);
    read_snap(s); chk("R9 snapshot", s, pat(300));
    wr(BASE + 12'h4, 1);
    chk("R9 released after", locked_o, 0);

    // R11 decision without delimiter
    @(negedge clk); msg_valid = 1; msg_type = 2'd0;
    @(negedge clk); msg_valid = 0;
    rd(BASE + 12'h4, d); chk("R11 no stale lock", d, 0);

    finish_run();
  end
endmodule